// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each bus cycle into eight active-low chip-select lines. Every channel has two registers that software writes over a small register bus. The first holds a 16-bit base that is compared with the upper half of the bus address. The second holds a 16-bit don't-care mask for that compare, plus a set of control bits. Because a mask can free any of the upper address bits, one channel can cover several regions that are not next to each other. A channel's region is 2^(16 + set mask bits) bytes in total.

A channel drives its select low only when all of the following hold:
- a transfer is valid;
- the address matches the channel's base on every bit the mask does not free;
- the channel is enabled;
- the cycle's type is allowed.

Write protection blocks write cycles without flagging any error. Per-type blocking bits exclude supervisor/user code/data cycles, and a separate bit excludes CPU-space cycles. For cycles issued by another master or by DMA, an override bit decides whether the four supervisor/user type bits still apply. The selects are combinational from the cycle inputs. Overlapping channels are not arbitrated: every channel that matches asserts its select.

Top module: `csel_decoder`

## Requirements
- R1: After reset every register reads 0, every channel is disabled, and `cs_n` is all ones for any cycle.
- R2: The base register of channel n is at offset 0x080 + 0x0C·n. A write takes effect at the next clock edge. A read returns the base in bits 31:16 and zero in bits 15:0.
- R3: The mask register of channel n is at offset 0x084 + 0x0C·n. Its bit fields are:
  - bits 31:16: mask;
  - bit 8: write protect;
  - bit 7: reserved, always reads 0;
  - bit 6: alternate-master override;
  - bit 5: CPU-space block;
  - bit 4: supervisor-code block;
  - bit 3: supervisor-data block;
  - bit 2: user-code block;
  - bit 1: user-data block;
  - bit 0: enable.

  Any other offset reads 0.
- R4: A channel matches when `bus_addr[31:16]` equals its base on every bit where the mask is 0. Mask bits set to 1 are don't-care, so base 0x0000 with mask 0x0008 matches upper addresses 0x0000 and 0x0008 only.
- R5: Over all 65536 upper-address values, a channel matches exactly 2^(popcount of mask) of them. For example, mask 0x01FF covers 32 MB and mask 0x00FF covers 16 MB.
- R6: A channel whose enable bit is 0 never drives its select low.
- R7: With write protect set, a matching write cycle leaves the select high and a matching read cycle drives it low.
- R8: When `bus_cpu` is 0, a matching cycle is blocked if the bit for its type is set. The type bits are: supervisor code (bit 4), supervisor data (bit 3), user code (bit 2) and user data (bit 1). When `bus_cpu` is 1, only bit 5 blocks the cycle.
- R9: When `bus_alt` is 1 and bit 6 is 0, bits 4..1 are ignored. When bit 6 is 1, bits 4..1 apply as in R8.
- R10: With `bus_valid` low, `cs_n` is all ones.
- R11: Several matching channels assert their selects together, with no priority between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Transfer-valid strobe |
| bus_addr | input | 32 | Bus address |
| bus_write | input | 1 | 1 = write cycle |
| bus_super | input | 1 | 1 = supervisor, 0 = user |
| bus_code | input | 1 | 1 = code (program) fetch, 0 = data |
| bus_cpu | input | 1 | 1 = CPU-space or interrupt-acknowledge cycle |
| bus_alt | input | 1 | 1 = cycle issued by another master or DMA |
| cs_n | output | 8 | Active-low chip selects, bit n for channel n |

## Verification
The assertions assume that `reg_addr` and `reg_we` change only away from the rising edge. They also assume that the cycle inputs are stable whenever they are sampled, since the selects are purely combinational. The bench writes registers only on falling edges, while the decode is idle. It then sweeps every upper-address value with cycle attributes taken from a scrambled counter. This way the write, privilege, code/data, CPU-space and other-master inputs take every combination across each channel's region and its edges.

// File: rtl/csel_decoder.sv
module csel_decoder #(
  parameter int NCH      = 8,
  parameter int AW       = 32,
  parameter int GRAN     = 16,
  parameter int RAW      = 8,
  parameter int BASE_OFS = 'h80,
  parameter int STRIDE   = 'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_write,
  input  logic             bus_super,
  input  logic             bus_code,
  input  logic             bus_cpu,
  input  logic             bus_alt,
  output logic [NCH-1:0]   cs_n
);
  localparam int CW   = AW - GRAN;
  localparam int B_V  = 0;
  localparam int B_UD = 1;
  localparam int B_UC = 2;
  localparam int B_SD = 3;
  localparam int B_SC = 4;
  localparam int B_CI = 5;
  localparam int B_AM = 6;
  localparam int B_WP = 8;

  logic [NCH-1:0][31:0] rd_v;
  logic [CW-1:0] tag;
  logic unused_bits;

  assign tag = bus_addr[AW-1:GRAN];
  assign unused_bits = ^{reg_wdata[15:9], bus_addr[GRAN-1:0]};

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [RAW-1:0] A_BASE = RAW'(BASE_OFS + STRIDE * n);
    localparam logic [RAW-1:0] A_MASK = RAW'(BASE_OFS + 4 + STRIDE * n);
    logic [CW-1:0] base_q, bam_q;
    logic [8:0]    ctl_q;
    logic          hit, blk, sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        bam_q  <= '0;
        ctl_q  <= '0;
      end else if (reg_we) begin
        if (reg_addr == A_BASE) base_q <= reg_wdata[31:32-CW];
        if (reg_addr == A_MASK) begin
          bam_q <= reg_wdata[31:32-CW];
          ctl_q <= {reg_wdata[8], 1'b0, reg_wdata[6:0]};
        end
      end
    end

    assign hit = ((tag ^ base_q) & ~bam_q) == '0;

    always_comb begin
      if (bus_cpu)                      blk = ctl_q[B_CI];
      else if (bus_alt && !ctl_q[B_AM]) blk = 1'b0;
      else if (bus_super)               blk = bus_code ? ctl_q[B_SC] : ctl_q[B_SD];
      else                              blk = bus_code ? ctl_q[B_UC] : ctl_q[B_UD];
    end

    assign sel = bus_valid && ctl_q[B_V] && hit && !(bus_write && ctl_q[B_WP]) && !blk;
    assign cs_n[n] = !sel;

    assign rd_v[n] = (reg_addr == A_BASE) ? {base_q, {(32-CW){1'b0}}} :
                     (reg_addr == A_MASK) ? {bam_q, 7'b0, ctl_q} : 32'b0;

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[B_V] |-> cs_n[n]);
    p_wp_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_write && ctl_q[B_WP]) |-> cs_n[n]);
    p_select_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[n] |-> ((tag & ~bam_q) == (base_q & ~bam_q)));
    p_base_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_BASE) |=> base_q == $past(reg_wdata[31:32-CW]));
    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_MASK) |=> (bam_q == $past(reg_wdata[31:32-CW])) && !ctl_q[7]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NCH; n++) reg_rdata |= rd_v[n];
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> &cs_n);
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7]);
endmodule

// File: tb/csel_decoder_tb.sv
module csel_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic bus_valid = 0, bus_write = 0, bus_super = 0, bus_code = 0, bus_cpu = 0, bus_alt = 0;
  logic [31:0] bus_addr = 0;
  logic [7:0] cs_n;
  int nchk = 0, nfail = 0;
  logic [15:0] mb [8];
  logic [15:0] mm [8];
  logic [8:0]  mc [8];

  always #5 clk = ~clk;

  csel_decoder dut_i (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_valid, .bus_addr, .bus_write, .bus_super, .bus_code, .bus_cpu, .bus_alt, .cs_n);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cyc(input logic [31:0] a, input logic v, w, s, c, p, x);
    bus_addr = a; bus_valid = v; bus_write = w; bus_super = s;
    bus_code = c; bus_cpu = p; bus_alt = x; #1;
  endtask

  function automatic logic [7:0] model(input logic [31:0] a, input logic v, w, s, c, p, x);
    logic [7:0] r = 8'hFF;
    for (int n = 0; n < 8; n++) begin
      logic match, blk;
      match = ((a[31:16] & ~mm[n]) == (mb[n] & ~mm[n]));
      if (p) blk = mc[n][5];
      else if (x && !mc[n][6]) blk = 0;
      else blk = mc[n][s ? (c ? 4 : 3) : (c ? 2 : 1)];
      if (v && mc[n][0] && match && !(w && mc[n][8]) && !blk) r[n] = 0;
    end
    return r;
  endfunction

  task automatic setch(input int n, input logic [15:0] b, input logic [15:0] m, input logic [8:0] c);
    wr(8'(8'h80 + 12 * n), {b, 16'h0});
    wr(8'(8'h84 + 12 * n), {m, 7'b0, c});
    mb[n] = b; mm[n] = m; mc[n] = {c[8], 1'b0, c[6:0]};
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h80 + 12 * n), d); chk("R1 base", d, 0);
      rd(8'(8'h84 + 12 * n), d); chk("R1 mask", d, 0);
    end
    cyc(32'h0000_1234, 1, 0, 1, 0, 0, 0); chk("R1 cs", {24'h0, cs_n}, 32'hFF);
    cyc(32'hFFFF_0000, 1, 1, 0, 1, 0, 1); chk("R1 cs", {24'h0, cs_n}, 32'hFF);
    cyc(0, 0, 0, 0, 0, 0, 0);

    setch(0, 16'h0000, 16'h0008, 9'h001);
    setch(1, 16'h0200, 16'h00FF, 9'h001);
    setch(2, 16'h0000, 16'h01FF, 9'h101);
    setch(3, 16'h4000, 16'h0F0F, 9'h013);
    setch(4, 16'h4000, 16'h0F0F, 9'h053);
    setch(5, 16'h8000, 16'h7FFF, 9'h021);
    setch(6, 16'hFFFF, 16'h0000, 9'h1FE);
    setch(7, 16'hFFFF, 16'h0000, 9'h001);

    // R2 / R3 readback, reserved bit 7 reads 0
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h80 + 12 * n), d); chk("R2 base readback", d, {mb[n], 16'h0});
      rd(8'(8'h84 + 12 * n), d); chk("R3 mask readback", d, {mm[n], 7'b0, mc[n]});
    end
    rd(8'h7C, d); chk("R3 unmapped", d, 0);
    rd(8'h88, d); chk("R3 unmapped", d, 0);

    // R4 non-contiguous region
    cyc(32'h0008_0010, 1, 0, 1, 0, 0, 0); chk("R4 upper hole hit", {31'h0, cs_n[0]}, 0);
    cyc(32'h0001_0000, 1, 0, 1, 0, 0, 0); chk("R4 gap miss", {31'h0, cs_n[0]}, 1);
    // R11 overlap: ch0 and ch2 both at 0
    cyc(32'h0000_0000, 1, 0, 1, 0, 0, 0); chk("R11 overlap", {30'h0, cs_n[2], cs_n[0]}, 0);
    // R7 write protect
    cyc(32'h0100_0000, 1, 1, 1, 0, 0, 0); chk("R7 write blocked", {31'h0, cs_n[2]}, 1);
    cyc(32'h0100_0000, 1, 0, 1, 0, 0, 0); chk("R7 read selected", {31'h0, cs_n[2]}, 0);
    // R8 type blocks
    cyc(32'h4000_0000, 1, 0, 1, 1, 0, 0); chk("R8 sup code blocked", {30'h0, cs_n[4], cs_n[3]}, 3);
    cyc(32'h4000_0000, 1, 0, 1, 0, 0, 0); chk("R8 sup data ok", {30'h0, cs_n[4], cs_n[3]}, 0);
    cyc(32'h8000_0000, 1, 0, 1, 0, 1, 0); chk("R8 cpu space blocked", {31'h0, cs_n[5]}, 1);
    cyc(32'h4000_0000, 1, 0, 1, 1, 1, 0); chk("R8 cpu space ignores type", {30'h0, cs_n[4], cs_n[3]}, 0);
    // R9 alternate master
    cyc(32'h4000_0000, 1, 0, 1, 1, 0, 1); chk("R9 alt override", {30'h0, cs_n[4], cs_n[3]}, 32'h2);
    // R6 disabled channel
    cyc(32'hFFFF_0000, 1, 0, 0, 0, 0, 0); chk("R6 disabled", {30'h0, cs_n[7], cs_n[6]}, 32'h1);
    // R10 no transfer
    cyc(32'h0000_0000, 0, 0, 1, 0, 0, 0); chk("R10 idle", {24'h0, cs_n}, 32'hFF);

    // R4/R8/R9 sweep over every upper address with scrambled attributes
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] k;
      logic [31:0] a;
      k = 16'(i) ^ 16'(i >> 4) ^ 16'(i >> 9) ^ 16'(i * 5);
      a = {16'(i), 16'(i * 37)};
      cyc(a, k[5] | k[6], k[0], k[1], k[2], k[3] & k[4], k[4]);
      chk("R4 sweep", {24'h0, cs_n}, {24'h0, model(a, k[5] | k[6], k[0], k[1], k[2], k[3] & k[4], k[4])});
    end

    // R5 region size
    c0 = 0; c1 = 0; c2 = 0;
    for (int i = 0; i < 65536; i++) begin
      cyc({16'(i), 16'hABCD}, 1, 0, 1, 0, 0, 0);
      c0 += int'(!cs_n[0]); c1 += int'(!cs_n[1]); c2 += int'(!cs_n[2]);
    end
    chk("R5 size ch0", c0, 2);
    chk("R5 size ch1", c1, 256);
    chk("R5 size ch2", c2, 512);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule